// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

This block merges sixteen external interrupt levels with a software-interrupt word into one pending-level mask. It then decides, once per clock, whether the processor should receive a hard interrupt request, and which trap-type code goes with it. The two timer-match bits of the software word do not stand for their own levels. Either one of them raises level 14 instead.

A request is raised only for a level strictly above the current processor interrupt level, and only while interrupts are globally enabled. A busy vector-interrupt path freezes the arbiter completely, because vector interrupts rank above every external level. A trap already being serviced at a non-zero trap level blocks a lower-ranked external interrupt from displacing it. The chosen code and the request line are both registers, so they follow their inputs by one clock.

Top module: `pil_arbiter`

## Requirements
- R1: After the asynchronous active-low reset, `irqReq` is 0 and `trapIdx` is 0.
- R2: The pending mask is `extLevels` ORed with `softInt[15:0]`. Bit 0 of `softInt` (tick match) and bit 16 of `softInt` (system-tick match) are never used as levels in their own right.
- R3: If `softInt[0]` or `softInt[16]` is 1, level 14 of the pending mask is set.
- R4: While `vecBusy` is 1, `irqReq` and `trapIdx` keep their values on the next clock.
- R5: If the pending mask, read as an unsigned number, is less than 2 shifted left by `curPil`, both `irqReq` and `trapIdx` are 0 on the next clock. This applies when `vecBusy` is 0, whatever the value of `intEnable`.
- R6: Otherwise, with `intEnable` at 1, the highest set level L of the pending mask is chosen, and `trapIdx` becomes 0x40 + L with `irqReq` at 1. The chosen level always lies in the range `curPil`+1 to 15.
- R7: When `trapLevel` is non-zero, `trapType[8:4]` equals 5'h04, and `trapType` is greater than the candidate code, the outputs keep their values.
- R8: When the candidate code equals the one already held in `trapIdx`, the outputs do not change.
- R9: With `intEnable` at 0 and an eligible level pending, an active request is dropped, and `trapIdx` returns to 0 on the next clock.
- R10: Each output update takes effect on the first rising clock edge after the inputs that cause it. `irqReq` is 1 exactly when `trapIdx` is non-zero, and then `trapIdx[8:4]` is 5'h04.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extLevels | input | 16 | External interrupt levels, bit n is level n |
| softInt | input | 17 | Software-interrupt word: bit 0 tick match, bit 16 system-tick match, bits 1..15 levels |
| curPil | input | 4 | Current processor interrupt level |
| intEnable | input | 1 | Global interrupt enable |
| trapLevel | input | 3 | Current trap nesting level |
| trapType | input | 9 | Trap type of the trap in progress |
| vecBusy | input | 1 | Vector interrupt pending; freezes the arbiter |
| irqReq | output | 1 | Hard interrupt request |
| trapIdx | output | 9 | Selected trap-type code, 0 when idle |

## Verification
Wrong held state appears at the ports directly. A stale `trapIdx` shows up as a code that differs from the highest eligible level one clock after the inputs settle. A lost freeze under `vecBusy` or under nesting shows up as a change that should not have happened. A request left standing shows up as `irqReq` at 1 after the level was masked or interrupts were disabled. Because every output is one register away from its inputs, each of these faults can be seen within a single clock. A reference model compared on every cycle therefore catches it on the cycle it occurs.

// File: rtl/pil_arb_pkg.sv
package pil_arb_pkg;
  localparam int NUM_LEVELS = 16;
  localparam int SOFT_W     = 17;
  localparam int PIL_W      = 4;
  localparam int TL_W       = 3;
  localparam int TT_W       = 9;
  localparam int TICK_BIT   = 0;
  localparam int STICK_BIT  = 16;
  localparam int CLK_LEVEL  = 14;
  localparam int FAM_LSB    = 4;
  localparam int FAM_W      = TT_W - FAM_LSB;
  localparam logic [FAM_W-1:0] EXT_FAMILY = 5'h04;
  localparam logic [TT_W-1:0]  EXT_BASE   = 9'h040;
  localparam int LVL_IDX_W  = $clog2(NUM_LEVELS);

  typedef struct packed {
    logic load;   // latch candidate code and raise request
    logic clear;  // drop request and zero the code
  } arbStrobes_t;
endpackage

// File: rtl/pil_arb_datapath.sv
module pil_arb_datapath
  import pil_arb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] extLevels,
  input  logic [SOFT_W-1:0]     softInt,
  input  logic [PIL_W-1:0]      curPil,
  input  logic [TL_W-1:0]       trapLevel,
  input  logic [TT_W-1:0]       trapType,
  input  arbStrobes_t           strobes,
  output logic                  eligible,
  output logic                  nestBlocked,
  output logic                  sameType,
  output logic                  irqReq,
  output logic [TT_W-1:0]       trapIdx
);
  localparam int CMP_W = NUM_LEVELS + 1;

  logic [NUM_LEVELS-1:0] softLevels;
  logic [NUM_LEVELS-1:0] pendMask;
  logic                  timerHit;
  logic [LVL_IDX_W-1:0]  topLevel;
  logic [TT_W-1:0]       candType;
  logic [CMP_W-1:0]      threshold;

  // Timer-match bits never count as levels of their own.
  for (genvar b = 0; b < NUM_LEVELS; b++) begin : g_soft
    if (b == TICK_BIT || b == STICK_BIT) begin : g_timer
      assign softLevels[b] = 1'b0;
    end else begin : g_plain
      assign softLevels[b] = softInt[b];
    end
  end

  assign timerHit = softInt[TICK_BIT] | softInt[STICK_BIT];

  always_comb begin
    pendMask = extLevels | softLevels;
    pendMask[CLK_LEVEL] = pendMask[CLK_LEVEL] | timerHit;
  end

  assign threshold = CMP_W'(2) << curPil;
  assign eligible  = {1'b0, pendMask} >= threshold;

  // Highest set level wins.
  always_comb begin
    topLevel = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (pendMask[i]) topLevel = LVL_IDX_W'(i);
    end
  end

  assign candType    = EXT_BASE | TT_W'(topLevel);
  assign nestBlocked = (trapLevel != '0) &&
                       (trapType[TT_W-1:FAM_LSB] == EXT_FAMILY) &&
                       (trapType > candType);
  assign sameType    = (trapIdx == candType);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq  <= 1'b0;
      trapIdx <= '0;
    end else if (strobes.clear) begin
      irqReq  <= 1'b0;
      trapIdx <= '0;
    end else if (strobes.load) begin
      irqReq  <= 1'b1;
      trapIdx <= candType;
    end
  end
endmodule

// File: rtl/pil_arb_control.sv
module pil_arb_control
  import pil_arb_pkg::*;
(
  input  logic        vecBusy,
  input  logic        intEnable,
  input  logic        eligible,
  input  logic        nestBlocked,
  input  logic        sameType,
  input  logic        irqReq,
  output arbStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (!vecBusy) begin
      if (!eligible) begin
        strobes.clear = 1'b1;
      end else if (intEnable) begin
        strobes.load = !nestBlocked && !sameType;
      end else begin
        strobes.clear = irqReq;
      end
    end
  end
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter
  import pil_arb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] extLevels,
  input  logic [SOFT_W-1:0]     softInt,
  input  logic [PIL_W-1:0]      curPil,
  input  logic                  intEnable,
  input  logic [TL_W-1:0]       trapLevel,
  input  logic [TT_W-1:0]       trapType,
  input  logic                  vecBusy,
  output logic                  irqReq,
  output logic [TT_W-1:0]       trapIdx
);
  arbStrobes_t strobes;
  logic eligible, nestBlocked, sameType;

  pil_arb_datapath u_dp (
    .clk, .rstN, .extLevels, .softInt, .curPil, .trapLevel, .trapType,
    .strobes, .eligible, .nestBlocked, .sameType, .irqReq, .trapIdx
  );

  pil_arb_control u_ctl (
    .vecBusy, .intEnable, .eligible, .nestBlocked, .sameType, .irqReq,
    .strobes
  );
endmodule

// File: rtl/pil_arb_checker.sv
module pil_arb_checker
  import pil_arb_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_LEVELS-1:0] extLevels,
  input logic [SOFT_W-1:0]     softInt,
  input logic [PIL_W-1:0]      curPil,
  input logic                  intEnable,
  input logic [TL_W-1:0]       trapLevel,
  input logic [TT_W-1:0]       trapType,
  input logic                  vecBusy,
  input logic                  irqReq,
  input logic [TT_W-1:0]       trapIdx
);
  logic [NUM_LEVELS-1:0] chkPend;
  logic                  chkLow;

  always_comb begin
    chkPend = extLevels | softInt[NUM_LEVELS-1:0];
    chkPend[TICK_BIT] = extLevels[TICK_BIT];
    if (softInt[TICK_BIT] || softInt[STICK_BIT]) chkPend[CLK_LEVEL] = 1'b1;
  end
  assign chkLow = {1'b0, chkPend} < ((NUM_LEVELS+1)'(2) << curPil);

  a_r4_vec_freeze: assert property (@(posedge clk) disable iff (!rstN)
    vecBusy |=> ($stable(irqReq) && $stable(trapIdx)));

  a_r5_below_pil_clears: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && chkLow) |=> (!irqReq && trapIdx == '0));

  a_r9_disable_drops: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && !intEnable && irqReq) |=> (!irqReq && trapIdx == '0));

  a_r10_req_pairs_idx: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (trapIdx != '0));

  a_r10_idx_family: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (trapIdx[TT_W-1:FAM_LSB] == EXT_FAMILY));

  a_r6_rise_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> ($past(intEnable) && !$past(vecBusy)));

  a_r7_no_lower_nest: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(trapIdx) && trapIdx != '0) |->
      !($past(trapLevel) != '0 &&
        $past(trapType[TT_W-1:FAM_LSB]) == EXT_FAMILY &&
        $past(trapType) > trapIdx));
endmodule

bind pil_arbiter pil_arb_checker u_chk (
  .clk(clk), .rstN(rstN), .extLevels(extLevels), .softInt(softInt),
  .curPil(curPil), .intEnable(intEnable), .trapLevel(trapLevel),
  .trapType(trapType), .vecBusy(vecBusy), .irqReq(irqReq), .trapIdx(trapIdx)
);

// File: tb/pil_arbiter_bench.sv
`timescale 1ns/1ps
module pil_arbiter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] extLevels = '0;
  logic [16:0] softInt = '0;
  logic [3:0]  curPil = '0;
  logic        intEnable = 1'b0;
  logic [2:0]  trapLevel = '0;
  logic [8:0]  trapType = '0;
  logic        vecBusy = 1'b0;
  logic        irqReq;
  logic [8:0]  trapIdx;

  int checks = 0;
  int fails  = 0;
  string curTag = "R1";
  logic       expReq = 1'b0;
  logic [8:0] expIdx = '0;

  always #4 clk = ~clk;

  pil_arbiter u_pil_arbiter (
    .clk, .rstN, .extLevels, .softInt, .curPil, .intEnable,
    .trapLevel, .trapType, .vecBusy, .irqReq, .trapIdx
  );

  // Behavioural reference model.
  always @(posedge clk or negedge rstN) begin
    int pend;
    int best;
    int cand;
    if (!rstN) begin
      expReq <= 1'b0;
      expIdx <= '0;
    end else if (!vecBusy) begin
      pend = int'(extLevels);
      for (int b = 1; b < 16; b++) if (softInt[b]) pend = pend | (1 << b);
      if (softInt[0] || softInt[16]) pend = pend | (1 << 14);
      if (pend < (2 << curPil)) begin
        expReq <= 1'b0;
        expIdx <= '0;
      end else if (intEnable) begin
        best = -1;
        for (int l = 15; l > int'(curPil); l--)
          if (best < 0 && ((pend >> l) & 1) == 1) best = l;
        cand = 64 + best;
        if (trapLevel != 0 && int'(trapType) > cand && (int'(trapType) / 16) == 4) begin
        end else if (int'(expIdx) != cand) begin
          expReq <= 1'b1;
          expIdx <= 9'(cand);
        end
      end else if (expReq) begin
        expReq <= 1'b0;
        expIdx <= '0;
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      check({curTag, " req"}, int'(irqReq), int'(expReq));
      check({curTag, " idx"}, int'(trapIdx), int'(expIdx));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Sample one clock after the drive, after the negedge compare.
  task automatic settle;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 reset req", int'(irqReq), 0);
    check("R1 reset idx", int'(trapIdx), 0);
    rstN = 1'b1;
    tick(1);

    curTag = "R6";
    intEnable = 1'b1;
    extLevels = 16'h0022;
    settle();
    check("R6 level5", int'(trapIdx), 'h45);
    check("R10 req with idx", int'(irqReq), 1);
    tick(0);
    extLevels = 16'h0222;
    settle();
    check("R6 level9", int'(trapIdx), 'h49);

    curTag = "R8";
    tick(3);
    check("R8 stable", int'(trapIdx), 'h49);

    curTag = "R2";
    extLevels = '0;
    softInt = 17'h00008;
    settle();
    check("R2 soft level3", int'(trapIdx), 'h43);
    tick(0);
    softInt = 17'h00001;
    settle();
    check("R3 tick to 14", int'(trapIdx), 'h4E);
    tick(0);
    softInt = 17'h00000;
    settle();
    check("R2 tick alone not level0", int'(irqReq), 0);
    tick(0);
    softInt = 17'h10000;
    curTag = "R3";
    settle();
    check("R3 stick to 14", int'(trapIdx), 'h4E);

    curTag = "R5";
    tick(0);
    softInt = '0;
    extLevels = 16'h03FF;
    curPil = 4'd9;
    settle();
    check("R5 below pil", int'(trapIdx), 0);
    tick(0);
    extLevels = 16'hFFFF;
    curPil = 4'd15;
    settle();
    check("R5 pil15", int'(irqReq), 0);
    tick(0);
    curPil = 4'd9;
    extLevels = 16'h0400;
    settle();
    check("R6 just above pil", int'(trapIdx), 'h4A);

    curTag = "R4";
    tick(0);
    vecBusy = 1'b1;
    extLevels = 16'h8000;
    settle();
    check("R4 freeze raise", int'(trapIdx), 'h4A);
    tick(0);
    extLevels = '0;
    settle();
    check("R4 freeze clear", int'(irqReq), 1);
    tick(0);
    vecBusy = 1'b0;
    settle();
    check("R4 release", int'(irqReq), 0);

    curTag = "R7";
    tick(0);
    curPil = 4'd0;
    trapLevel = 3'd1;
    trapType = 9'h04C;
    extLevels = 16'h0008;
    settle();
    check("R7 nested blocked", int'(irqReq), 0);
    tick(0);
    extLevels = 16'h2000;
    settle();
    check("R7 higher allowed", int'(trapIdx), 'h4D);
    tick(0);
    extLevels = 16'h0008;
    settle();
    check("R7 lower holds old", int'(trapIdx), 'h4D);
    tick(0);
    trapType = 9'h022;
    settle();
    check("R7 non-ext type", int'(trapIdx), 'h43);
    tick(0);
    trapType = 9'h04C;
    trapLevel = 3'd0;
    extLevels = 16'h0010;
    settle();
    check("R7 tl zero", int'(trapIdx), 'h44);

    curTag = "R9";
    tick(0);
    intEnable = 1'b0;
    settle();
    check("R9 disabled drops", int'(irqReq), 0);
    check("R9 disabled idx", int'(trapIdx), 0);
    tick(0);
    intEnable = 1'b1;
    settle();
    check("R9 reenable", int'(trapIdx), 'h44);

    curTag = "R10";
    for (int k = 0; k < 4000; k++) begin
      tick(1);
      extLevels = 16'($urandom) & 16'($urandom);
      softInt   = 17'($urandom) & 17'($urandom) & 17'($urandom);
      curPil    = 4'($urandom_range(0, 15));
      intEnable = ($urandom_range(0, 7) != 0);
      trapLevel = 3'($urandom_range(0, 2));
      trapType  = ($urandom_range(0, 3) == 0) ? 9'($urandom) : 9'(64 + $urandom_range(0, 15));
      vecBusy   = ($urandom_range(0, 9) == 0);
    end
    tick(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule